// File: doc/BRIEF.md
# Auxiliary UART Register Front-End

A word-addressed register block for a small auxiliary UART. A host on a 32-bit register bus reads and writes single words. Received bytes arrive on a byte-wide ready/valid input and are held in a circular receive FIFO. The host drains that FIFO by reading the data register. A write to the data register sends its low byte out at once on a transmit strobe. Serial timing is not part of this block, so the transmit path is treated as always empty.

A single interrupt line combines the two enabled sources. Several status words return fixed patterns built on the always-empty transmit model. The extended status word also reports the receive fill level. Bus accesses take effect on the rising clock edge. Read data is combinational from the address during the access cycle.

Top module: `miniuart_regs`

## Requirements
- R1: After reset the receive count, read pointer and interrupt enables are zero. `irq` is low, `rx_ready` is high, and the enable register reads 0xC0.
- R2: Writes to the interrupt-enable register (0x44) keep only bit 0 (transmit) and bit 1 (receive). Reads return those bits ORed with 0xC0.
- R3: `irq` is high when transmit is enabled, or when receive is enabled and the FIFO is not empty. It follows every access and every accepted byte in the next cycle.
- R4: A read of the identify register (0x48) returns 0xC0, plus 0x4 if the FIFO holds data and 0x2 otherwise, plus 0x1 when `irq` is low.
- R5: A write to 0x48 with bit 1 set empties the FIFO. A byte accepted in the same cycle is discarded. A write with bit 1 clear changes nothing.
- R6: The line status register (0x54) reads 0x60, with bit 0 set when the FIFO is not empty.
- R7: The extended status register (0x64) reads 0x30E. Bit 0 is set when the FIFO is not empty, and bits 19:16 carry the fill count.
- R8: A read of the data register (0x40) returns the oldest byte and pops it, in arrival order with wraparound. A read when the FIFO is empty returns the byte in the slot at the read pointer and changes no state.
- R9: `rx_ready` is high exactly while fewer than 8 bytes are held. Accepted bytes land behind the stored ones, modulo 8.
- R10: 0x00 reads 1 when `irq` is high and 0 otherwise. 0x04 reads 1 and 0x60 reads 3. Offsets 0x4C, 0x50, 0x58, 0x5C, 0x68 and any unmapped offset read 0, and writes to them have no effect.
- R11: A write to 0x40 raises `tx_strobe` in the same cycle, with `tx_data` equal to the low byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_strobe | output | 1 | Transmit byte emitted this cycle |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or pointer shows at the ports in the cycle after the bad update. It appears in the extended status fill field, the line status bit, `rx_ready` and `irq`, and in a data read that returns a byte out of arrival order. A dropped flush or a lost enable bit shows up in the identify code and in `irq` one cycle later. Because every cycle compares `irq`, `rx_ready` and any read word against a reference queue, a divergence is reported within one cycle of the first visible effect.

// File: rtl/miniuart_regs.sv
module miniuart_regs #(
  parameter int DEPTH = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  output logic          tx_strobe,
  output logic [7:0]    tx_data,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_SUM  = AW'(8'h00);
  localparam logic [AW-1:0] A_ENA  = AW'(8'h04);
  localparam logic [AW-1:0] A_DATA = AW'(8'h40);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h44);
  localparam logic [AW-1:0] A_IID  = AW'(8'h48);
  localparam logic [AW-1:0] A_LST  = AW'(8'h54);
  localparam logic [AW-1:0] A_CTL  = AW'(8'h60);
  localparam logic [AW-1:0] A_XST  = AW'(8'h64);

  logic [7:0]    fifo [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] cnt;
  logic [1:0]    ien;
  logic [CW:0]   slot_sum;
  logic [PW-1:0] wr_slot;

  wire rd       = bus_sel & ~bus_wr;
  wire wr       = bus_sel & bus_wr;
  wire has_data = (cnt != '0);
  wire push     = rx_valid & rx_ready;
  wire pop      = rd & (bus_addr == A_DATA) & has_data;
  wire flush    = wr & (bus_addr == A_IID) & bus_wdata[1];

  assign rx_ready  = (cnt < CW'(DEPTH));
  assign irq       = ien[0] | (ien[1] & has_data);
  assign tx_strobe = wr & (bus_addr == A_DATA);
  assign tx_data   = bus_wdata[7:0];

  assign slot_sum = {1'b0, (CW)'(rd_ptr)} + {1'b0, cnt};
  assign wr_slot  = (slot_sum >= (CW+1)'(DEPTH)) ? PW'(slot_sum - (CW+1)'(DEPTH)) : PW'(slot_sum);

  always_ff @(posedge clk)
    if (push) fifo[wr_slot] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
      ien    <= '0;
    end else begin
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + PW'(1);
      if (flush) cnt <= '0;
      else       cnt <= cnt + CW'(push) - CW'(pop);
      if (wr && bus_addr == A_IEN) ien <= bus_wdata[1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_SUM:  bus_rdata = {31'd0, irq};
        A_ENA:  bus_rdata = 32'd1;
        A_DATA: bus_rdata = {24'd0, fifo[rd_ptr]};
        A_IEN:  bus_rdata = {24'd0, 8'hC0 | {6'd0, ien}};
        A_IID:  bus_rdata = {24'd0, 8'hC0 | (has_data ? 8'h04 : 8'h02) | {7'd0, ~irq}};
        A_LST:  bus_rdata = {24'd0, 8'h60 | {7'd0, has_data}};
        A_CTL:  bus_rdata = 32'd3;
        A_XST:  bus_rdata = 32'h30E | {31'd0, has_data} | (32'(cnt) << 16);
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |=> cnt == $past(cnt) + CW'(1)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0) && !(ien[1] && !ien[0] && irq)); // R5
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == A_DATA && !has_data && !push) |=> $stable(rd_ptr) && (cnt == '0)); // R8
  AST_IEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_IEN) |=> ien == $past(bus_wdata[1:0])); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !pop && !flush) |=> cnt == CW'(DEPTH)); // R9
endmodule

// File: tb/miniuart_regs_test.sv
`timescale 1ns/1ps
module miniuart_regs_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, rx_valid = 0;
  logic [7:0] bus_addr = 0, rx_data = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic rx_ready, tx_strobe, irq;
  logic [7:0] tx_data;

  miniuart_regs uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq));

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  logic [7:0] m_mem [8];
  int m_ptr = 0, m_cnt = 0;
  logic [1:0] m_ien = 0;

  function automatic logic m_irq();
    return m_ien[0] | (m_ien[1] & (m_cnt != 0));
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      8'h00: return {31'd0, m_irq()};
      8'h04: return 32'd1;
      8'h40: return {24'd0, m_mem[m_ptr]};
      8'h44: return {30'd0, m_ien} | 32'hC0;
      8'h48: return 32'hC0 | ((m_cnt != 0) ? 32'h4 : 32'h2) | {31'd0, ~m_irq()};
      8'h54: return 32'h60 | {31'd0, m_cnt != 0};
      8'h60: return 32'd3;
      8'h64: return 32'h30E | {31'd0, m_cnt != 0} | (32'(m_cnt) << 16);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h40: return "R8";
      8'h44: return "R2";
      8'h48: return "R4";
      8'h54: return "R6";
      8'h64: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic s, logic w, logic [7:0] a, logic [31:0] d, logic v, logic [7:0] b);
    bit push, pop, flush;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; rx_valid = v; rx_data = b;
    #1;
    chk("R9 rx_ready", {31'd0, rx_ready}, {31'd0, m_cnt < 8});
    chk("R3 irq", {31'd0, irq}, {31'd0, m_irq()});
    chk("R11 tx_strobe", {31'd0, tx_strobe}, {31'd0, s & w & (a == 8'h40)});
    if (s && w && a == 8'h40) chk("R11 tx_data", {24'd0, tx_data}, {24'd0, d[7:0]});
    if (s && !w) chk(tag_of(a), bus_rdata, exp_rd(a));
    push  = v && (m_cnt < 8);
    pop   = s && !w && a == 8'h40 && m_cnt != 0;
    flush = s && w && a == 8'h48 && d[1];
    @(posedge clk);
    if (push) m_mem[(m_ptr + m_cnt) % 8] = b;
    if (pop) m_ptr = (m_ptr + 1) % 8;
    if (flush) m_cnt = 0; else m_cnt = m_cnt + int'(push) - int'(pop);
    if (s && w && a == 8'h44) m_ien = d[1:0];
  endtask

  task automatic rd_(logic [7:0] a); cyc(1, 0, a, 0, 0, 0); endtask
  task automatic wr_(logic [7:0] a, logic [31:0] d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic rx_(logic [7:0] b); cyc(0, 0, 0, 0, 1, b); endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  logic [7:0] addrs [12] = '{8'h00, 8'h04, 8'h40, 8'h44, 8'h48, 8'h4C,
                             8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64};

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) m_mem[i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    #1;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 1);
    rd_(8'h44); rd_(8'h64); rd_(8'h54); rd_(8'h48);
    // R9 fill to full with wraparound later
    for (int i = 0; i < 10; i++) rx_(8'h10 + 8'(i));
    rd_(8'h64);
    // R8 pop in order
    for (int i = 0; i < 3; i++) rd_(8'h40);
    for (int i = 0; i < 3; i++) rx_(8'hA0 + 8'(i));
    for (int i = 0; i < 9; i++) rd_(8'h40);
    // R8 empty read keeps stale slot
    rd_(8'h40); rd_(8'h64);
    // R2 / R3 / R4 enables
    wr_(8'h44, 32'hFF); rd_(8'h44); rd_(8'h48); rd_(8'h00);
    wr_(8'h44, 32'h2); rd_(8'h48); rx_(8'h55); rd_(8'h48); rd_(8'h00);
    // R5 flush, with simultaneous byte; bit1 clear does nothing
    rx_(8'h56);
    wr_(8'h48, 32'h1); rd_(8'h64);
    cyc(1, 1, 8'h48, 32'h2, 1, 8'h77); rd_(8'h64); rd_(8'h48);
    // R10 reserved writes ignored
    foreach (addrs[k]) if (addrs[k] != 8'h40 && addrs[k] != 8'h44 && addrs[k] != 8'h48)
      wr_(addrs[k], 32'hFFFF_FFFF);
    foreach (addrs[k]) rd_(addrs[k]);
    rd_(8'hFC);
    // R11 transmit
    wr_(8'h40, 32'h1234_56C3);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 99);
      int rp = (i / 500) % 2 ? 70 : 30;
      logic v = ($urandom_range(0, 99) < rp);
      logic [7:0] b = 8'($urandom);
      if (op < 30)      cyc(1, 0, 8'h40, 0, v, b);
      else if (op < 55) cyc(1, 0, addrs[$urandom_range(0, 11)], 0, v, b);
      else if (op < 62) cyc(1, 1, 8'h44, $urandom, v, b);
      else if (op < 65) cyc(1, 1, 8'h48, $urandom, v, b);
      else if (op < 72) cyc(1, 1, 8'h40, $urandom, v, b);
      else if (op < 77) cyc(1, 1, addrs[$urandom_range(0, 11)], $urandom, v, b);
      else              cyc(0, 0, 0, 0, v, b);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule